// File: doc/BRIEF.md
# DMA Channel Register File with Launch Aliases

This block is the software-visible register set of one DMA channel. It sits behind a word-addressed bus slave port and holds the source pointer, the destination pointer, a transfer length and a control word. The same four physical registers appear in four alias groups, each ordered differently. The last word of every group is a launch alias, so the CPU or another DMA channel can reprogram the channel and set it running with nothing more than a burst of plain writes.

The block tracks two counts. One is a reload length for the next sequence. The other is a remaining count for the sequence in progress. It hands the transfer engine a one-cycle start pulse, takes one decrement pulse per completed transfer, and returns a done pulse when the remaining count runs out. A chain input lets a neighbouring channel launch this one on completion. A launch alias written with zero does not launch anything. It serves as an end-of-chain marker and can raise the channel interrupt. The interrupt status bit is sticky, is cleared by writing 1 to it, and is gated by a mask bit.

Top module: `dma_chan_regs`

## Requirements
- R1: Word index w < 16 selects group w[3:2] and slot w[1:0]. The slots map as follows: group 0 = pointer-src, pointer-dst, length, control; group 1 = control, pointer-src, pointer-dst, length; group 2 = control, length, pointer-src, pointer-dst; group 3 = control, pointer-dst, length, pointer-src. Every alias of a register reads the same value. Word 16 is the interrupt status (bit 0) and word 17 is the interrupt mask (bit 0). Words 18 to 31 read as zero and ignore writes.
- R2: A write to slots 0 to 2 of any group updates the register and never launches the channel.
- R3: A nonzero write to slot 3 (the launch alias) while idle updates the register, copies the reload length into the remaining count, and raises busy_o and a one-cycle start_o in the cycle after the write. When slot 3 is the length, the value just written is the one used.
- R4: A chain_i pulse while idle launches the channel in the same way as R3.
- R5: Launch requests (alias writes or chain_i) while busy are ignored, although the registers are still written.
- R6: Reading any length alias returns the remaining count. Writing the length changes only the reload value and leaves the remaining count untouched.
- R7: Each dec_i while busy lowers the remaining count by one. The decrement from 1 clears busy_o and pulses done_o in the next cycle. dec_i while idle has no effect.
- R8: A launch with a reload length of zero leaves busy_o low and pulses done_o in the next cycle.
- R9: The quiet flag is control bit 1, and control resets to 0x2. Bit 31 of a control read returns busy_o, and writes to bit 31 are dropped. With quiet clear, every sequence end (R7 or R8) sets the interrupt status.
- R10: A zero write to a launch alias does not launch the channel. It sets the interrupt status only if the quiet flag held before that write was 1.
- R11: The interrupt status is sticky and is cleared by writing 1 to bit 0 of word 16. A set in the same cycle wins over the clear. irq_o is status AND mask, and the mask resets to 0.
- R12: rd_addr_o and wr_addr_o always show the current source and destination pointer registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 5 | Word index of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| chain_i | input | 1 | Launch request from another channel |
| dec_i | input | 1 | One transfer completed by the engine |
| start_o | output | 1 | One-cycle launch pulse to the engine |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle sequence-end pulse |
| irq_o | output | 1 | Masked interrupt |
| rd_addr_o | output | 32 | Source pointer |
| wr_addr_o | output | 32 | Destination pointer |

## Verification
Every registered result (busy_o, start_o, done_o, irq_o and the remaining count) appears exactly one clock edge after the write, chain pulse or decrement that causes it. The bench drives each stimulus for a single edge and samples one time unit after that edge, before the next stimulus goes out. Register readback is combinational, so the bench reads it by changing bus_addr mid-cycle with no write strobe, so that reading never disturbs state. The same-cycle case of a sequence end and a status clear is driven as a single stimulus cycle.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;
  localparam int unsigned ALIAS_WORDS = 16;
  localparam int unsigned ISTAT_WORD  = 16;
  localparam int unsigned IMASK_WORD  = 17;

  typedef enum logic [2:0] {
    RK_NONE, RK_RPTR, RK_WPTR, RK_CNT, RK_CTRL, RK_ISTAT, RK_IMASK
  } reg_kind_e;

  // Register reached by a given slot in a given alias group.
  function automatic reg_kind_e slot_kind(input logic [1:0] grp, input logic [1:0] slot);
    reg_kind_e k;
    k = RK_NONE;
    case (grp)
      2'd0: case (slot)
              2'd0: k = RK_RPTR;  2'd1: k = RK_WPTR;
              2'd2: k = RK_CNT;   default: k = RK_CTRL;
            endcase
      2'd1: case (slot)
              2'd0: k = RK_CTRL;  2'd1: k = RK_RPTR;
              2'd2: k = RK_WPTR;  default: k = RK_CNT;
            endcase
      2'd2: case (slot)
              2'd0: k = RK_CTRL;  2'd1: k = RK_CNT;
              2'd2: k = RK_RPTR;  default: k = RK_WPTR;
            endcase
      default: case (slot)
              2'd0: k = RK_CTRL;  2'd1: k = RK_WPTR;
              2'd2: k = RK_CNT;   default: k = RK_RPTR;
            endcase
    endcase
    return k;
  endfunction
endpackage

// File: rtl/dmarf_decode.sv
module dmarf_decode
  import dmarf_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic              trig_slot
);
  localparam logic [ADDR_W-1:0] ISTAT_A = ADDR_W'(ISTAT_WORD);
  localparam logic [ADDR_W-1:0] IMASK_A = ADDR_W'(IMASK_WORD);

  logic in_alias;

  generate
    if (ADDR_W > 4) begin : g_wide
      assign in_alias = (addr[ADDR_W-1:4] == '0);
    end else begin : g_narrow
      assign in_alias = 1'b1;
    end
  endgenerate

  always_comb begin
    kind      = RK_NONE;
    trig_slot = 1'b0;
    if (in_alias) begin
      kind      = slot_kind(addr[3:2], addr[1:0]);
      trig_slot = (addr[1:0] == 2'd3);
    end else if (addr == ISTAT_A) begin
      kind = RK_ISTAT;
    end else if (addr == IMASK_A) begin
      kind = RK_IMASK;
    end
  end
endmodule

// File: rtl/dmarf_seq.sv
module dmarf_seq #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [CNT_W-1:0] reload,
  input  logic             dec_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] rem_o,
  output logic             start_o,
  output logic             done_o,
  output logic             seq_end_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] rem_after(input logic [CNT_W-1:0] r);
    return r - ONE;
  endfunction

  logic start_acc, zero_start, real_start, last_dec;

  assign start_acc  = start_req && !busy_o;
  assign zero_start = start_acc && (reload == '0);
  assign real_start = start_acc && (reload != '0);
  assign last_dec   = busy_o && dec_i && (rem_o == ONE);
  assign seq_end_o  = last_dec || zero_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      rem_o   <= '0;
      start_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      start_o <= real_start;
      done_o  <= seq_end_o;
      if (real_start) begin
        rem_o  <= reload;
        busy_o <= 1'b1;
      end else if (busy_o && dec_i) begin
        rem_o <= rem_after(rem_o);
        if (last_dec) busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dmarf_irq.sv
module dmarf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_we,
  input  logic mask_d,
  output logic stat_o,
  output logic mask_o,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_o <= 1'b0;
      mask_o <= 1'b0;
    end else begin
      if (set_i)      stat_o <= 1'b1;
      else if (clr_i) stat_o <= 1'b0;
      if (mask_we)    mask_o <= mask_d;
    end
  end

  assign irq_o = stat_o && mask_o;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmarf_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned QUIET_BIT = 1,
  parameter logic [DATA_W-2:0] CTRL_RST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              chain_i,
  input  logic              dec_i,
  output logic              start_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0] wr_addr_o
);
  localparam int unsigned CTRL_W = DATA_W - 1;
  localparam int unsigned CNT_PAD = DATA_W - CNT_W;

  reg_kind_e         kind;
  logic              trig_slot;
  logic [DATA_W-1:0] rptr_q, wptr_q;
  logic [CNT_W-1:0]  reload_q, reload_next, rem_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              quiet, trig_wr, null_ev, start_req, seq_end;
  logic              istat, imask, istat_set, istat_clr;

  dmarf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .kind(kind), .trig_slot(trig_slot)
  );

  // Named events shared by the sequencer, the interrupt unit and the checker
  assign quiet       = ctrl_q[QUIET_BIT];
  assign trig_wr     = bus_wr && trig_slot;
  assign null_ev     = trig_wr && (bus_wdata == '0);
  assign start_req   = (trig_wr && (bus_wdata != '0)) || chain_i;
  assign reload_next = (bus_wr && kind == RK_CNT) ? bus_wdata[CNT_W-1:0] : reload_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q   <= '0;
      wptr_q   <= '0;
      reload_q <= '0;
      ctrl_q   <= CTRL_RST;
    end else if (bus_wr) begin
      case (kind)
        RK_RPTR: rptr_q   <= bus_wdata;
        RK_WPTR: wptr_q   <= bus_wdata;
        RK_CNT:  reload_q <= bus_wdata[CNT_W-1:0];
        RK_CTRL: ctrl_q   <= bus_wdata[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  dmarf_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .reload(reload_next),
    .dec_i(dec_i), .busy_o(busy_o), .rem_o(rem_q), .start_o(start_o),
    .done_o(done_o), .seq_end_o(seq_end)
  );

  assign istat_set = (seq_end && !quiet) || (null_ev && quiet);
  assign istat_clr = bus_wr && (kind == RK_ISTAT) && bus_wdata[0];

  dmarf_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(istat_set), .clr_i(istat_clr),
    .mask_we(bus_wr && kind == RK_IMASK), .mask_d(bus_wdata[0]),
    .stat_o(istat), .mask_o(imask), .irq_o(irq_o)
  );

  always_comb begin
    case (kind)
      RK_RPTR:  bus_rdata = rptr_q;
      RK_WPTR:  bus_rdata = wptr_q;
      RK_CNT:   bus_rdata = {{CNT_PAD{1'b0}}, rem_q};
      RK_CTRL:  bus_rdata = {busy_o, ctrl_q};
      RK_ISTAT: bus_rdata = {{(DATA_W-1){1'b0}}, istat};
      RK_IMASK: bus_rdata = {{(DATA_W-1){1'b0}}, imask};
      default:  bus_rdata = '0;
    endcase
  end

  assign rd_addr_o = rptr_q;
  assign wr_addr_o = wptr_q;
endmodule

// File: rtl/dmarf_chk.sv
module dmarf_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             start,
  input logic             done,
  input logic             dec,
  input logic [CNT_W-1:0] rem,
  input logic             istat,
  input logic             clr,
  input logic             null_ev,
  input logic             quiet
);
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (busy && rem != '0));
  // R7
  rem_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dec && rem > CNT_W'(1)) |=> (busy && rem == $past(rem) - CNT_W'(1)));
  // R7
  last_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dec && rem == CNT_W'(1)) |=> (!busy && done));
  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(dec && rem == CNT_W'(1))) |=> (busy && !start));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10
  null_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (null_ev && quiet) |=> istat);
  // R11
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (istat && !clr) |=> istat);
endmodule

bind dma_chan_regs dmarf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_o), .start(start_o), .done(done_o),
  .dec(dec_i), .rem(rem_q), .istat(istat), .clr(istat_clr),
  .null_ev(null_ev), .quiet(quiet)
);

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        chain_i = 1'b0, dec_i = 1'b0;
  logic        start_o, busy_o, done_o, irq_o;
  logic [31:0] rd_addr_o, wr_addr_o;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_regs u_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chain_i(chain_i),
    .dec_i(dec_i), .start_o(start_o), .busy_o(busy_o), .done_o(done_o),
    .irq_o(irq_o), .rd_addr_o(rd_addr_o), .wr_addr_o(wr_addr_o)
  );

  typedef struct packed {
    logic [4:0]  a;
    logic        w;
    logic [31:0] d;
    logic        dc;
    logic        ch;
    logic        eb;
    logic [15:0] er;
    logic        ei;
    logic        es;
    logic        ed;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 30;
  // Fields: word, wr, data, dec, chain | busy, remaining, irq, start, done | requirement
  localparam vec_t VT [NV] = '{
    '{5'd17,1'b1,32'h1,   1'b0,1'b0, 1'b0,16'd0,1'b0,1'b0,1'b0, 4'd11}, // R11 mask on
    '{5'd2, 1'b1,32'h3,   1'b0,1'b0, 1'b0,16'd0,1'b0,1'b0,1'b0, 4'd6},  // R6 reload only
    '{5'd3, 1'b1,32'h2,   1'b0,1'b0, 1'b1,16'd3,1'b0,1'b1,1'b0, 4'd3},  // R3 control launch
    '{5'd0, 1'b0,32'h0,   1'b1,1'b0, 1'b1,16'd2,1'b0,1'b0,1'b0, 4'd7},  // R7
    '{5'd14,1'b1,32'h5,   1'b0,1'b0, 1'b1,16'd2,1'b0,1'b0,1'b0, 4'd6},  // R6 busy reload
    '{5'd0, 1'b0,32'h0,   1'b1,1'b0, 1'b1,16'd1,1'b0,1'b0,1'b0, 4'd7},  // R7
    '{5'd0, 1'b0,32'h0,   1'b1,1'b0, 1'b0,16'd0,1'b0,1'b0,1'b1, 4'd7},  // R7 end, quiet
    '{5'd15,1'b1,32'h1000,1'b0,1'b0, 1'b1,16'd5,1'b0,1'b1,1'b0, 4'd3},  // R3 src launch
    '{5'd15,1'b1,32'h2000,1'b0,1'b0, 1'b1,16'd5,1'b0,1'b0,1'b0, 4'd5},  // R5 ignored
    '{5'd0, 1'b0,32'h0,   1'b1,1'b0, 1'b1,16'd4,1'b0,1'b0,1'b0, 4'd7},
    '{5'd0, 1'b0,32'h0,   1'b1,1'b0, 1'b1,16'd3,1'b0,1'b0,1'b0, 4'd7},
    '{5'd0, 1'b0,32'h0,   1'b1,1'b0, 1'b1,16'd2,1'b0,1'b0,1'b0, 4'd7},
    '{5'd0, 1'b0,32'h0,   1'b1,1'b0, 1'b1,16'd1,1'b0,1'b0,1'b0, 4'd7},
    '{5'd0, 1'b0,32'h0,   1'b1,1'b0, 1'b0,16'd0,1'b0,1'b0,1'b1, 4'd7},
    '{5'd15,1'b1,32'h0,   1'b0,1'b0, 1'b0,16'd0,1'b1,1'b0,1'b0, 4'd10}, // R10 null, quiet
    '{5'd16,1'b1,32'h1,   1'b0,1'b0, 1'b0,16'd0,1'b0,1'b0,1'b0, 4'd11}, // R11 clear
    '{5'd12,1'b1,32'h0,   1'b0,1'b0, 1'b0,16'd0,1'b0,1'b0,1'b0, 4'd2},  // R2 quiet off
    '{5'd9, 1'b1,32'h1,   1'b0,1'b0, 1'b0,16'd0,1'b0,1'b0,1'b0, 4'd2},  // R2
    '{5'd0, 1'b0,32'h0,   1'b0,1'b1, 1'b1,16'd1,1'b0,1'b1,1'b0, 4'd4},  // R4 chain
    '{5'd0, 1'b0,32'h0,   1'b1,1'b0, 1'b0,16'd0,1'b1,1'b0,1'b1, 4'd9},  // R9 end irq
    '{5'd16,1'b1,32'h1,   1'b0,1'b0, 1'b0,16'd0,1'b0,1'b0,1'b0, 4'd11},
    '{5'd7, 1'b1,32'h2,   1'b0,1'b0, 1'b1,16'd2,1'b0,1'b1,1'b0, 4'd3},  // R3 length launch
    '{5'd0, 1'b0,32'h0,   1'b1,1'b0, 1'b1,16'd1,1'b0,1'b0,1'b0, 4'd7},
    '{5'd0, 1'b0,32'h0,   1'b1,1'b0, 1'b0,16'd0,1'b1,1'b0,1'b1, 4'd9},
    '{5'd16,1'b1,32'h1,   1'b0,1'b0, 1'b0,16'd0,1'b0,1'b0,1'b0, 4'd11},
    '{5'd11,1'b1,32'h0,   1'b0,1'b0, 1'b0,16'd0,1'b0,1'b0,1'b0, 4'd10}, // R10 null, loud
    '{5'd14,1'b1,32'h0,   1'b0,1'b0, 1'b0,16'd0,1'b0,1'b0,1'b0, 4'd6},
    '{5'd0, 1'b0,32'h0,   1'b0,1'b1, 1'b0,16'd0,1'b1,1'b0,1'b1, 4'd8},  // R8 zero length
    '{5'd16,1'b1,32'h1,   1'b0,1'b0, 1'b0,16'd0,1'b0,1'b0,1'b0, 4'd11},
    '{5'd0, 1'b0,32'h0,   1'b1,1'b0, 1'b0,16'd0,1'b0,1'b0,1'b0, 4'd7}   // R7 idle dec
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] a, input logic w, input logic [31:0] d,
                       input logic dc, input logic ch);
    bus_addr = a; bus_wr = w; bus_wdata = d; dec_i = dc; chain_i = ch;
    @(posedge clk); #1;
    bus_wr = 1'b0; dec_i = 1'b0; chain_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_CYCLES && !finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // Reset state: R9 control default, R11 mask/status, R6 count
    chk("R7", "busy", {31'b0, busy_o}, 32'h0);
    chk("R11", "irq", {31'b0, irq_o}, 32'h0);
    rd(5'd3, v);  chk("R9", "ctrl reset", v, 32'h2);
    rd(5'd12, v); chk("R1", "ctrl alias reset", v, 32'h2);
    rd(5'd2, v);  chk("R6", "count reset", v, 32'h0);
    rd(5'd16, v); chk("R11", "status reset", v, 32'h0);
    rd(5'd17, v); chk("R11", "mask reset", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VT[i].rq);
      drive(VT[i].a, VT[i].w, VT[i].d, VT[i].dc, VT[i].ch);
      chk(rq, $sformatf("row %0d busy", i), {31'b0, busy_o}, {31'b0, VT[i].eb});
      chk(rq, $sformatf("row %0d start", i), {31'b0, start_o}, {31'b0, VT[i].es});
      chk(rq, $sformatf("row %0d done", i), {31'b0, done_o}, {31'b0, VT[i].ed});
      chk(rq, $sformatf("row %0d irq", i), {31'b0, irq_o}, {31'b0, VT[i].ei});
      rd(5'd2, v);
      chk(rq, $sformatf("row %0d remaining", i), v, {16'b0, VT[i].er});
    end

    // R11: sequence end and status clear in one cycle, set wins
    drive(5'd14, 1'b1, 32'h1, 1'b0, 1'b0);
    drive(5'd0, 1'b0, 32'h0, 1'b0, 1'b1);
    drive(5'd16, 1'b1, 32'h1, 1'b1, 1'b0);
    chk("R11", "set beats clear", {31'b0, irq_o}, 32'h1);
    drive(5'd16, 1'b1, 32'h1, 1'b0, 1'b0);
    chk("R11", "clear", {31'b0, irq_o}, 32'h0);

    // R1 / R12: source and destination aliases
    drive(5'd0, 1'b1, 32'hA5A5_0000, 1'b0, 1'b0);
    rd(5'd5, v);  chk("R1", "src alias g1", v, 32'hA5A5_0000);
    rd(5'd10, v); chk("R1", "src alias g2", v, 32'hA5A5_0000);
    rd(5'd15, v); chk("R1", "src alias g3", v, 32'hA5A5_0000);
    chk("R12", "rd_addr_o", rd_addr_o, 32'hA5A5_0000);
    drive(5'd13, 1'b1, 32'h0000_1234, 1'b0, 1'b0);
    chk("R2", "plain dst write no launch", {31'b0, busy_o}, 32'h0);
    rd(5'd1, v);  chk("R1", "dst alias g0", v, 32'h1234);
    rd(5'd6, v);  chk("R1", "dst alias g1", v, 32'h1234);
    rd(5'd11, v); chk("R1", "dst alias g2", v, 32'h1234);
    chk("R12", "wr_addr_o", wr_addr_o, 32'h1234);

    // R9: control bit 31 reads busy, writes to it dropped
    drive(5'd8, 1'b1, 32'hFFFF_FFFD, 1'b0, 1'b0);
    rd(5'd3, v);  chk("R9", "ctrl bit31 dropped", v, 32'h7FFF_FFFD);
    drive(5'd14, 1'b1, 32'h2, 1'b0, 1'b0);
    drive(5'd0, 1'b0, 32'h0, 1'b0, 1'b1);
    rd(5'd4, v);  chk("R9", "ctrl bit31 busy", v, 32'hFFFF_FFFD);
    drive(5'd0, 1'b0, 32'h0, 1'b1, 1'b0);
    drive(5'd0, 1'b0, 32'h0, 1'b1, 1'b0);
    chk("R9", "end irq quiet clear", {31'b0, irq_o}, 32'h1);
    drive(5'd16, 1'b1, 32'h1, 1'b0, 1'b0);

    // R1: unmapped word ignores writes and reads zero
    drive(5'd20, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
    rd(5'd20, v); chk("R1", "unmapped read", v, 32'h0);
    rd(5'd17, v); chk("R1", "mask untouched", v, 32'h1);
    rd(5'd16, v); chk("R1", "status untouched", v, 32'h0);
    chk("R1", "no launch", {31'b0, busy_o}, 32'h0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule